// File: doc/BRIEF.md
# Nonhead Miss Predictor with Early Redirect Target

This block sits beside a trace cache that chains fixed-size segments into long traces. A nonhead miss happens when the next basic block the program actually runs differs from the one the current trace continues into. Without help, that is only found in the execute stage, many cycles after the trace cache access. The block predicts such a miss at the moment the trace cache is accessed. When it has one, it also gives the address that fetch should jump to: the head of a new trace.

Each fetch address is mixed with a global history of recent miss outcomes. The result indexes a table of 3-bit saturating counters. A small direct-mapped target buffer, tagged by the upper address bits, keeps the correct next address seen on earlier misses. When execute resolves an access, the resolve port trains the counter, shifts the history and, on a miss, refills the target buffer. Table depths are parameters. At full size the counter index is 16 bits wide (64K counters) and the target buffer is 12 bits wide (4K entries). The defaults are smaller so the block is cheap to elaborate.

Top module: `nhm_predictor`

## Requirements
- R1: After reset every counter holds 3 and every target entry is invalid, so a lookup predicts no miss and gives no redirect. While reset is held all outputs are 0.
- R2: A lookup (`fetch_valid`=1) gives its result in the next cycle with `pred_valid`=1. `pred_miss`=1 exactly when the selected counter is 4 or more. The counter is selected by the low `IDX_W` bits of (history XOR `fetch_addr[15:0]`).
- R3: A resolve with `res_nh_miss`=1 increments the counter selected by (history XOR `res_addr[15:0]`), stopping at 7. A resolve with `res_nh_miss`=0 decrements it, stopping at 0.
- R4: Each resolve shifts the 16-bit history left by one and puts the outcome in bit 0 (1 = miss). The history only changes on a resolve.
- R5: A resolve with `res_nh_miss`=1 writes `res_target` into the target entry selected by `res_addr[TB_IDX_W-1:0]`, marks it valid and tags it with `res_addr[31:TB_IDX_W]`. A resolve that reports no miss leaves the target buffer unchanged.
- R6: `redir_valid`=1 only when `pred_miss`=1 and the target entry for the looked-up address is valid with a matching tag. `redir_addr` then carries the stored target; otherwise it is 0.
- R7: A lookup whose address shares the entry index but not the tag of a stored target gives no redirect.
- R8: A lookup and a resolve in the same cycle: the lookup sees counters, history and target buffer as they were before that resolve.
- R9: In a cycle after one with `fetch_valid`=0, `pred_valid`, `pred_miss`, `redir_valid` and `redir_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Trace cache access this cycle |
| fetch_addr | input | 32 | Fetch address of the access |
| res_valid | input | 1 | An access has been resolved in execute |
| res_addr | input | 32 | Fetch address of the resolved access |
| res_nh_miss | input | 1 | 1 when the resolved access was a nonhead miss |
| res_target | input | 32 | Correct next address for the resolved access |
| pred_valid | output | 1 | Prediction result is present |
| pred_miss | output | 1 | Nonhead miss predicted |
| redir_valid | output | 1 | Early redirect requested |
| redir_addr | output | 32 | Redirect target, 0 when no redirect |

## Verification
Every internal state element shows up at the ports one cycle after a lookup that selects it. A counter that saturates wrongly or wraps shows up as a `pred_miss` that flips the wrong way within a few lookups at a fixed index. A history that shifts wrongly moves every later index, so the first lookup after the bad resolve disagrees with a history-tracking reference. A target entry that is corrupted, mistagged or written on a hit shows up as a wrong or missing redirect at the next lookup of that address once its counter predicts a miss. The bench therefore looks up every cycle and drives long runs of all-miss and all-hit outcomes, so that the history and the counters reach their limits.

// File: rtl/nhm_pkg.sv
package nhm_pkg;
    localparam int CTR_W = 3;
    localparam logic [CTR_W-1:0] CTR_INIT   = 3'd3;
    localparam logic [CTR_W-1:0] CTR_MAX    = 3'd7;
    localparam logic [CTR_W-1:0] CTR_MIN    = 3'd0;
    localparam logic [CTR_W-1:0] CTR_THRESH = 3'd4;

    // saturating step of a miss counter
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c, input logic miss);
        logic [CTR_W-1:0] r;
        if (miss) r = (c == CTR_MAX) ? c : c + 1'b1;
        else      r = (c == CTR_MIN) ? c : c - 1'b1;
        return r;
    endfunction

    function automatic logic ctr_says_miss(input logic [CTR_W-1:0] c);
        return c >= CTR_THRESH;
    endfunction
endpackage

// File: rtl/nhm_history.sv
module nhm_history #(
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_miss,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) st_d.hist = {st_q.hist[HIST_W-2:0], upd_miss};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.hist;
endmodule

// File: rtl/nhm_counter_table.sv
module nhm_counter_table
    import nhm_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_miss,
    output logic             rd_miss
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             pred;
        logic             wr;
        logic [IDX_W-1:0] widx;
        logic [CTR_W-1:0] wval;
    } ctab_next_t;

    logic [CTR_W-1:0] ctr_q [DEPTH];
    logic             pred_q;
    ctab_next_t       nx_d;

    always_comb begin
        nx_d.pred = rd_en && ctr_says_miss(ctr_q[rd_idx]);
        nx_d.wr   = wr_en;
        nx_d.widx = wr_idx;
        nx_d.wval = ctr_step(ctr_q[wr_idx], wr_miss);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
        end else begin
            pred_q <= nx_d.pred;
            if (nx_d.wr) ctr_q[nx_d.widx] <= nx_d.wval;
        end
    end

    assign rd_miss = pred_q;
endmodule

// File: rtl/nhm_target_buffer.sv
module nhm_target_buffer #(
    parameter int ADDR_W   = 32,
    parameter int TB_IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_target,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target
);
    localparam int DEPTH = 1 << TB_IDX_W;
    localparam int TAG_W = ADDR_W - TB_IDX_W;

    typedef struct packed {
        logic                hit;
        logic [ADDR_W-1:0]   tgt;
        logic                wr;
        logic [TB_IDX_W-1:0] widx;
        logic [TAG_W-1:0]    wtag;
        logic [ADDR_W-1:0]   wtgt;
    } tb_next_t;

    logic                valid_q [DEPTH];
    logic [TAG_W-1:0]    tag_q   [DEPTH];
    logic [ADDR_W-1:0]   tgt_q   [DEPTH];
    logic                hit_q;
    logic [ADDR_W-1:0]   out_q;
    tb_next_t            nx_d;

    logic [TB_IDX_W-1:0] ridx;
    logic [TAG_W-1:0]    rtag;
    logic                match;

    always_comb begin
        ridx  = rd_addr[TB_IDX_W-1:0];
        rtag  = rd_addr[ADDR_W-1:TB_IDX_W];
        match = valid_q[ridx] && (tag_q[ridx] == rtag);
        nx_d.hit  = rd_en && match;
        nx_d.tgt  = (rd_en && match) ? tgt_q[ridx] : '0;
        nx_d.wr   = wr_en;
        nx_d.widx = wr_addr[TB_IDX_W-1:0];
        nx_d.wtag = wr_addr[ADDR_W-1:TB_IDX_W];
        nx_d.wtgt = wr_target;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            out_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                tgt_q[i]   <= '0;
            end
        end else begin
            hit_q <= nx_d.hit;
            out_q <= nx_d.tgt;
            if (nx_d.wr) begin
                valid_q[nx_d.widx] <= 1'b1;
                tag_q[nx_d.widx]   <= nx_d.wtag;
                tgt_q[nx_d.widx]   <= nx_d.wtgt;
            end
        end
    end

    assign rd_hit    = hit_q;
    assign rd_target = out_q;
endmodule

// File: rtl/nhm_predictor.sv
module nhm_predictor #(
    parameter int ADDR_W   = 32,
    parameter int HIST_W   = 16,
    parameter int IDX_W    = 10,
    parameter int TB_IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              res_nh_miss,
    input  logic [ADDR_W-1:0] res_target,
    output logic              pred_valid,
    output logic              pred_miss,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr
);
    typedef struct packed {
        logic pv;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] mix_rd, mix_wr;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              ctr_miss, tb_hit;
    logic [ADDR_W-1:0] tb_tgt;

    always_comb begin
        mix_rd  = hist_q ^ fetch_addr[HIST_W-1:0];
        mix_wr  = hist_q ^ res_addr[HIST_W-1:0];
        rd_idx  = mix_rd[IDX_W-1:0];
        wr_idx  = mix_wr[IDX_W-1:0];
        st_d.pv = fetch_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nhm_history #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .upd_en(res_valid), .upd_miss(res_nh_miss),
        .hist(hist_q)
    );

    nhm_counter_table #(.IDX_W(IDX_W)) u_ctab (
        .clk(clk), .rst_n(rst_n),
        .rd_en(fetch_valid), .rd_idx(rd_idx),
        .wr_en(res_valid), .wr_idx(wr_idx), .wr_miss(res_nh_miss),
        .rd_miss(ctr_miss)
    );

    nhm_target_buffer #(.ADDR_W(ADDR_W), .TB_IDX_W(TB_IDX_W)) u_tbuf (
        .clk(clk), .rst_n(rst_n),
        .rd_en(fetch_valid), .rd_addr(fetch_addr),
        .wr_en(res_valid && res_nh_miss), .wr_addr(res_addr), .wr_target(res_target),
        .rd_hit(tb_hit), .rd_target(tb_tgt)
    );

    assign pred_valid  = st_q.pv;
    assign pred_miss   = ctr_miss;
    assign redir_valid = ctr_miss && tb_hit;
    assign redir_addr  = (ctr_miss && tb_hit) ? tb_tgt : '0;
endmodule

// File: rtl/nhm_predictor_chk.sv
module nhm_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              res_valid,
    input logic              res_nh_miss,
    input logic              pred_valid,
    input logic              pred_miss,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic [HIST_W-1:0] hist_q
);
    AST_REDIR_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> pred_miss); // R6
    AST_NO_ADDR_WITHOUT_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> redir_addr == '0); // R6
    AST_QUIET_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (!pred_miss && !redir_valid)); // R9
    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid); // R2
    AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !pred_valid); // R9
    AST_HIST_TAKES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> hist_q[0] == $past(res_nh_miss)); // R4
    AST_HIST_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])); // R4
    AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hist_q)); // R4
endmodule

bind nhm_predictor nhm_predictor_chk #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .res_valid(res_valid), .res_nh_miss(res_nh_miss),
    .pred_valid(pred_valid), .pred_miss(pred_miss),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .hist_q(hist_q)
);

// File: tb/sim_nhm_predictor.sv
module sim_nhm_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 10;
    localparam int TB_IDX_W = 8;
    localparam int CDEPTH = 1 << IDX_W;
    localparam int TDEPTH = 1 << TB_IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_addr = '0;
    logic        res_nh_miss = 1'b0;
    logic [31:0] res_target = '0;
    logic        pred_valid, pred_miss, redir_valid;
    logic [31:0] redir_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nhm_predictor #(.IDX_W(IDX_W), .TB_IDX_W(TB_IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .res_valid(res_valid), .res_addr(res_addr), .res_nh_miss(res_nh_miss),
        .res_target(res_target), .pred_valid(pred_valid), .pred_miss(pred_miss),
        .redir_valid(redir_valid), .redir_addr(redir_addr)
    );

    // reference state built from the requirements
    int          m_ctr [CDEPTH];
    bit          m_tv  [TDEPTH];
    logic [31:0] m_tadr[TDEPTH];
    logic [31:0] m_ttgt[TDEPTH];
    logic [15:0] m_hist;

    task automatic model_reset();
        for (int i = 0; i < CDEPTH; i++) m_ctr[i] = 3;
        for (int i = 0; i < TDEPTH; i++) begin m_tv[i] = 0; m_tadr[i] = '0; m_ttgt[i] = '0; end
        m_hist = '0;
    endtask

    task automatic check(string req, logic [34:0] act, logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,miss,redir,addr} actual %b %b %b %h expected %b %b %b %h",
                     req, act[34], act[33], act[32], act[31:0], exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // drive one cycle at a falling edge, compare after the next rising edge
    task automatic step(string req, logic fv, logic [31:0] fa, logic rv, logic [31:0] ra,
                        logic rm, logic [31:0] rt);
        logic e_miss, e_hit;
        logic [31:0] e_tgt;
        int ci, ti;
        fetch_valid = fv; fetch_addr = fa;
        res_valid = rv; res_addr = ra; res_nh_miss = rm; res_target = rt;
        ci = int'((m_hist ^ fa[15:0]) & 16'(CDEPTH-1));
        ti = int'(fa[TB_IDX_W-1:0]);
        e_miss = fv && (m_ctr[ci] >= 4);                                    // R2
        e_hit  = fv && m_tv[ti] && (m_tadr[ti][31:TB_IDX_W] == fa[31:TB_IDX_W]); // R7
        e_tgt  = (e_miss && e_hit) ? m_ttgt[ti] : 32'h0;                    // R6
        if (rv) begin                                                       // R8: update after lookup
            ci = int'((m_hist ^ ra[15:0]) & 16'(CDEPTH-1));
            if (rm) begin
                if (m_ctr[ci] < 7) m_ctr[ci]++;                             // R3
                ti = int'(ra[TB_IDX_W-1:0]);
                m_tv[ti] = 1; m_tadr[ti] = ra; m_ttgt[ti] = rt;             // R5
            end else if (m_ctr[ci] > 0) m_ctr[ci]--;
            m_hist = {m_hist[14:0], rm};                                    // R4
        end
        @(posedge clk);
        @(negedge clk);
        check(req, {pred_valid, pred_miss, redir_valid, redir_addr},
              {fv, e_miss, e_miss && e_hit, e_tgt});
    endtask

    typedef struct packed {
        logic        fv;
        logic [31:0] fa;
        logic        rv;
        logic [31:0] ra;
        logic        rm;
        logic [31:0] rt;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 32'h0040_1230, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b1, 32'h0080_0000},
        '{1'b1, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b1, 32'h0080_0000},
        '{1'b0, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b1, 32'h0080_0040},
        '{1'b1, 32'h0040_1230, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 32'h7000_1230, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 32'h0000_5555, 1'b1, 32'h0000_5555, 1'b0, 32'hDEAD_0000},
        '{1'b1, 32'h0000_5555, 1'b1, 32'h0000_AAAA, 1'b1, 32'h1111_2222},
        '{1'b1, 32'h0000_AAAA, 1'b1, 32'h0000_AAAA, 1'b1, 32'h1111_2224},
        '{1'b1, 32'h0000_AAAA, 1'b1, 32'h0000_AAAA, 1'b1, 32'h1111_2228},
        '{1'b1, 32'h0000_AAAA, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0},
        '{1'b0, 32'h0,         1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 32'h0040_1230, 1'b0, 32'h0,         1'b0, 32'h0}
    };

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs held low during reset
        check("R1", {pred_valid, pred_miss, redir_valid, redir_addr}, 35'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {pred_valid, pred_miss, redir_valid, redir_addr}, 35'h0);
        step("R1", 1'b1, 32'h0040_1230, 1'b0, 32'h0, 1'b0, 32'h0);

        // table walk: mixed lookups and resolves, same-cycle cases (R8)
        foreach (VECS[i])
            step("R2/R8 vector", VECS[i].fv, VECS[i].fa, VECS[i].rv, VECS[i].ra,
                 VECS[i].rm, VECS[i].rt);

        // R3 upward saturation: history fills with ones, index then fixed
        for (int i = 0; i < 30; i++)
            step("R3 up", 1'b1, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b1, 32'h0090_0000 + 32'(i));
        // R6: redirect to latest stored target
        step("R6", 1'b1, 32'h0040_1230, 1'b0, 32'h0, 1'b0, 32'h0);
        // R7: same entry index, other tag
        step("R7", 1'b1, 32'h7000_1230, 1'b0, 32'h0, 1'b0, 32'h0);
        // R5: hit resolve to same entry must not overwrite the target
        step("R5", 1'b1, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b0, 32'hBAD0_BAD0);
        step("R5", 1'b1, 32'h0040_1230, 1'b0, 32'h0, 1'b0, 32'h0);
        // R3 downward saturation: history fills with zeros
        for (int i = 0; i < 30; i++)
            step("R3 down", 1'b1, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b0, 32'h0);
        for (int i = 0; i < 6; i++)
            step("R3 recover", 1'b1, 32'h0040_1230, 1'b1, 32'h0040_1231, 1'b1, 32'h00A0_0000);
        // R4: alternating outcomes walk the history through many patterns
        for (int i = 0; i < 40; i++)
            step("R4", 1'b1, 32'h0000_0100 + 32'(i * 7), 1'b1, 32'h0000_0100 + 32'(i * 3),
                 1'(i % 3 == 0), 32'h0C00_0000 + 32'(i));
        // R9: idle lookups
        step("R9", 1'b0, 32'h0040_1230, 1'b0, 32'h0, 1'b0, 32'h0);
        step("R9", 1'b0, 32'h0040_1230, 1'b1, 32'h0040_1230, 1'b1, 32'h1);

        // R1: reset mid-run clears learned state
        rst_n = 1'b0;
        fetch_valid = 1'b0; res_valid = 1'b0;
        @(negedge clk);
        check("R1", {pred_valid, pred_miss, redir_valid, redir_addr}, 35'h0);
        rst_n = 1'b1;
        model_reset();
        step("R1", 1'b1, 32'h0040_1230, 1'b0, 32'h0, 1'b0, 32'h0);
        step("R1", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule